// File: doc/BRIEF.md
# Supply-Loss Beam Shutdown Sequencer

This block orders the digital control levels of a display when its supply starts to collapse. A supply-drop flag, which may arrive from outside the clock domain, is brought in through a two-stage synchroniser. Once it is seen, the sequencer lets the vertical scan in progress run to its end, then waits for the following vertical flyback to finish. After that it enters a forced-beam phase. In that phase the fixed beam current is forced if the configuration allows it, and the vertical deflection either parks in the overscan position or keeps scanning, as a second configuration bit selects. Horizontal drive stays on throughout.

A power-on-reset-low indication overrides everything. From any state it sends the sequencer to a terminal off state, where horizontal drive and beam forcing are both switched off. Only the block reset leaves that state. The analog loops and deflection stages live outside the block. All pins are plain control and status levels, so there is no streaming handshake and no back-pressure.

Top module: `supply_loss_seq`

## Requirements
- R1: After reset the state output reads idle (one-hot 5'b00001). Horizontal drive enable and vertical run enable are 1, and force-beam and overscan hold are 0.
- R2: The supply-drop input passes through two synchroniser flops. If it goes high before clock edge N, the state reads wait-for-scan-end (5'b00010) after edge N+2 and still reads idle after edges N and N+1.
- R3: In wait-for-scan-end, a flyback-end strobe is ignored. A scan-end strobe moves the state to wait-for-flyback-end (5'b00100) on the next edge.
- R4: In wait-for-flyback-end, a scan-end strobe is ignored. A flyback-end strobe moves the state to forced-beam (5'b01000) on the next edge.
- R5: In forced-beam, the force-beam output equals the fixed-beam-enable configuration bit. In every other state it is 0.
- R6: Horizontal drive enable is 1 in every state except off.
- R7: In forced-beam with overscan mode 1, overscan hold is 1 and vertical run enable is 0. With overscan mode 0, overscan hold is 0 and vertical run enable is 1. Outside forced-beam and off, overscan hold is 0 and vertical run enable is 1.
- R8: When power-on-reset-low is high at an edge, the state reads off (5'b10000) after that edge, from any state. In off, all four control outputs are 0, and off is held until reset even after power-on-reset-low falls.
- R9: Once the sequence has left idle, deasserting the supply-drop input has no effect until reset.
- R10: In idle, scan-end and flyback-end strobes have no effect.
- R11: The state output is always exactly one-hot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| supply_drop_i | input | 1 | Supply-drop flag, asynchronous |
| scan_end_i | input | 1 | One-cycle strobe at the end of vertical scan |
| flyback_end_i | input | 1 | One-cycle strobe at the end of vertical flyback |
| fbc_en_i | input | 1 | Configuration: allow forcing the fixed beam current |
| overscan_mode_i | input | 1 | Configuration: 1 parks vertical in overscan, 0 keeps it running |
| por_low_i | input | 1 | Power-on-reset-low indication |
| force_beam_o | output | 1 | Force the fixed beam current |
| vhold_overscan_o | output | 1 | Hold vertical deflection at the overscan position |
| vrun_en_o | output | 1 | Vertical scan enable |
| hdrive_en_o | output | 1 | Horizontal drive enable |
| state_o | output | 5 | One-hot current state |

## Verification
The bench sends flyback strobes while the sequencer waits for scan end, and scan strobes while it waits for flyback end. A design that reacts to any vertical strobe would reach forced-beam one event too early. It counts edges through the synchroniser to catch a design that has one stage too many or too few. It drops the supply flag in mid-sequence to expose a design that returns to idle. It also raises power-on-reset-low in idle and in forced-beam and then releases it, which catches a design that leaves the off state or leaves the horizontal drive running.

// File: rtl/supply_loss_pkg.sv
package supply_loss_pkg;
  localparam int unsigned NSTATE = 5;

  typedef enum logic [NSTATE-1:0] {
    ST_IDLE   = 5'b00001,
    ST_WSCAN  = 5'b00010,
    ST_WFLY   = 5'b00100,
    ST_FORCED = 5'b01000,
    ST_OFF    = 5'b10000
  } seq_state_t;

  typedef struct packed {
    logic force_beam;
    logic vhold;
    logic vrun;
    logic hdrive;
  } ctrl_out_t;
endpackage

// File: rtl/drop_sync.sv
module drop_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import supply_loss_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       drop_sync_i,
  input  logic       scan_end_i,
  input  logic       flyback_end_i,
  input  logic       por_low_i,
  output seq_state_t state_o
);
  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (por_low_i) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_IDLE:   if (drop_sync_i)   state_d = ST_WSCAN;
        ST_WSCAN:  if (scan_end_i)    state_d = ST_WFLY;
        ST_WFLY:   if (flyback_end_i) state_d = ST_FORCED;
        ST_FORCED: state_d = ST_FORCED;
        ST_OFF:    state_d = ST_OFF;
        default:   state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  AST_ONEHOT_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(state_q)); // R11
  AST_POR_TO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    por_low_i |=> (state_q == ST_OFF)); // R8
  AST_OFF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OFF) |=> (state_q == ST_OFF)); // R8
  AST_FLY_NEEDS_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WSCAN && !scan_end_i && !por_low_i) |=> (state_q == ST_WSCAN)); // R3
  AST_FORCED_NEEDS_FLY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WFLY && !flyback_end_i && !por_low_i) |=> (state_q == ST_WFLY)); // R4
  AST_NO_RETURN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> (state_q != ST_IDLE)); // R9
endmodule

// File: rtl/out_decode.sv
module out_decode
  import supply_loss_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  seq_state_t state_i,
  input  logic       fbc_en_i,
  input  logic       overscan_mode_i,
  output ctrl_out_t  ctrl_o
);
  always_comb begin
    ctrl_o = '{force_beam: 1'b0, vhold: 1'b0, vrun: 1'b1, hdrive: 1'b1};
    unique case (state_i)
      ST_FORCED: begin
        ctrl_o.force_beam = fbc_en_i;
        ctrl_o.vhold      = overscan_mode_i;
        ctrl_o.vrun       = ~overscan_mode_i;
      end
      ST_OFF: begin
        ctrl_o = '{force_beam: 1'b0, vhold: 1'b0, vrun: 1'b0, hdrive: 1'b0};
      end
      default: ;
    endcase
  end

  AST_HDRIVE_ALIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i != ST_OFF) |-> ctrl_o.hdrive); // R6
  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == ST_OFF) |-> (ctrl_o == '0)); // R8
  AST_HOLD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_o.vhold && ctrl_o.vrun)); // R7
endmodule

// File: rtl/supply_loss_seq.sv
module supply_loss_seq
  import supply_loss_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_drop_i,
  input  logic              scan_end_i,
  input  logic              flyback_end_i,
  input  logic              fbc_en_i,
  input  logic              overscan_mode_i,
  input  logic              por_low_i,
  output logic              force_beam_o,
  output logic              vhold_overscan_o,
  output logic              vrun_en_o,
  output logic              hdrive_en_o,
  output logic [NSTATE-1:0] state_o
);
  logic       drop_s;
  seq_state_t state;
  ctrl_out_t  ctrl;

  drop_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (supply_drop_i),
    .sync_o  (drop_s)
  );

  seq_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .drop_sync_i   (drop_s),
    .scan_end_i    (scan_end_i),
    .flyback_end_i (flyback_end_i),
    .por_low_i     (por_low_i),
    .state_o       (state)
  );

  out_decode u_dec (
    .clk             (clk),
    .rst_n           (rst_n),
    .state_i         (state),
    .fbc_en_i        (fbc_en_i),
    .overscan_mode_i (overscan_mode_i),
    .ctrl_o          (ctrl)
  );

  assign force_beam_o     = ctrl.force_beam;
  assign vhold_overscan_o = ctrl.vhold;
  assign vrun_en_o        = ctrl.vrun;
  assign hdrive_en_o      = ctrl.hdrive;
  assign state_o          = state;

  AST_FORCE_ONLY_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    force_beam_o |-> (state_o == 5'b01000)); // R5
endmodule

// File: tb/tb_supply_loss_seq.sv
`timescale 1ns/1ps
module tb_supply_loss_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic drop = 1'b0, scan = 1'b0, fly = 1'b0, fbc = 1'b0, osm = 1'b0, por = 1'b0;
  logic force_b, vhold, vrun, hdrv;
  logic [4:0] st;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  typedef struct {
    logic [8:0] exp;
    string      req;
  } item_t;
  item_t sb[$];

  localparam logic [4:0] S_IDLE = 5'b00001, S_WSCAN = 5'b00010, S_WFLY = 5'b00100,
                         S_FORCED = 5'b01000, S_OFF = 5'b10000;

  always #2 clk = ~clk;

  supply_loss_seq dut (
    .clk(clk), .rst_n(rst_n), .supply_drop_i(drop), .scan_end_i(scan),
    .flyback_end_i(fly), .fbc_en_i(fbc), .overscan_mode_i(osm), .por_low_i(por),
    .force_beam_o(force_b), .vhold_overscan_o(vhold), .vrun_en_o(vrun),
    .hdrive_en_o(hdrv), .state_o(st)
  );

  // expected pack: {state, force, hold, vrun, hdrive}
  function automatic logic [8:0] pack(logic [4:0] s, logic f, logic h, logic v, logic d);
    return {s, f, h, v, d};
  endfunction

  // driver: set inputs before an edge, then queue the expected result of that edge
  task automatic step(input logic d, input logic sc, input logic fl, input logic fb,
                      input logic os, input logic pr, input logic [8:0] e, input string r);
    item_t it;
    @(negedge clk);
    drop = d; scan = sc; fly = fl; fbc = fb; osm = os; por = pr;
    @(posedge clk);
    it.exp = e; it.req = r;
    sb.push_back(it);
  endtask

  // monitor: compare one ns after each edge
  always @(posedge clk) begin
    #1;
    while (sb.size() > 0) begin
      item_t it;
      logic [8:0] act;
      it = sb.pop_front();
      act = {st, force_b, vhold, vrun, hdrv};
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s: actual=%b expected=%b", it.req, act, it.exp);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; drop = 0; scan = 0; fly = 0; fbc = 0; osm = 0; por = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    step(0,0,0,0,0,0, pack(S_IDLE,0,0,1,1), "R1");
    // R10 strobes ignored in idle
    step(0,1,0,0,0,0, pack(S_IDLE,0,0,1,1), "R10");
    step(0,0,1,0,0,0, pack(S_IDLE,0,0,1,1), "R10");
    // R2 two-flop synchroniser latency
    step(1,0,0,1,1,0, pack(S_IDLE,0,0,1,1), "R2");
    step(1,0,0,1,1,0, pack(S_IDLE,0,0,1,1), "R2");
    step(1,0,0,1,1,0, pack(S_WSCAN,0,0,1,1), "R2");
    // R3 flyback ignored while waiting for scan end; R9 drop released
    step(0,0,1,1,1,0, pack(S_WSCAN,0,0,1,1), "R3");
    step(0,0,0,1,1,0, pack(S_WSCAN,0,0,1,1), "R9");
    step(0,0,0,1,1,0, pack(S_WSCAN,0,0,1,1), "R9");
    step(0,1,0,1,1,0, pack(S_WFLY,0,0,1,1), "R3");
    // R4 scan ignored while waiting for flyback
    step(0,1,0,1,1,0, pack(S_WFLY,0,0,1,1), "R4");
    step(0,0,1,1,1,0, pack(S_FORCED,1,1,0,1), "R4");
    // R5 / R7 / R6 in forced phase
    step(0,0,0,1,0,0, pack(S_FORCED,1,0,1,1), "R7");
    step(0,0,0,0,0,0, pack(S_FORCED,0,0,1,1), "R5");
    step(0,0,0,0,1,0, pack(S_FORCED,0,1,0,1), "R6");
    // R8 power-on-reset-low from forced, then sticky
    step(0,0,0,1,1,1, pack(S_OFF,0,0,0,0), "R8");
    step(0,0,0,1,1,0, pack(S_OFF,0,0,0,0), "R8");
    step(1,1,1,1,0,0, pack(S_OFF,0,0,0,0), "R8");
    // R8 from idle
    do_reset();
    step(0,0,0,1,1,0, pack(S_IDLE,0,0,1,1), "R1");
    step(0,0,0,1,1,1, pack(S_OFF,0,0,0,0), "R8");
    step(0,0,0,1,1,0, pack(S_OFF,0,0,0,0), "R8");
    // R8 from wait-for-flyback, with forcing disabled path checked first
    do_reset();
    step(1,0,0,0,0,0, pack(S_IDLE,0,0,1,1), "R2");
    step(1,0,0,0,0,0, pack(S_IDLE,0,0,1,1), "R2");
    step(1,0,0,0,0,0, pack(S_WSCAN,0,0,1,1), "R2");
    step(1,1,0,0,0,0, pack(S_WFLY,0,0,1,1), "R3");
    step(1,0,0,0,0,1, pack(S_OFF,0,0,0,0), "R8");
    // R5 forcing disabled throughout a full sequence
    do_reset();
    step(1,0,0,0,0,0, pack(S_IDLE,0,0,1,1), "R2");
    step(1,0,0,0,0,0, pack(S_IDLE,0,0,1,1), "R2");
    step(0,1,0,0,0,0, pack(S_WSCAN,0,0,1,1), "R9");
    step(0,1,0,0,0,0, pack(S_WFLY,0,0,1,1), "R3");
    step(0,0,1,0,0,0, pack(S_FORCED,0,0,1,1), "R5");
    step(0,0,0,0,0,0, pack(S_FORCED,0,0,1,1), "R11");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule